// File: doc/BRIEF.md
# Adapter Reset and Init Sequencer

This block takes a network adapter's glue logic out of reset in a fixed order. It owns three active-low reset outputs: one for the chip core, one for the host system interface and one for the FIFO. It also owns an interrupt-control register and a FIFO threshold register, and it drives a line-rate select output. Three single-cycle command pulses start a sequence: bring-up (release the core only), full init, and power-down.

Full init first lets the core out of reset. It then pulls all three resets low in one write and holds them for a timed window. After the window it lets them go one per cycle, core first, then system interface, then FIFO. Last, it programs interrupt control and the FIFO threshold. Every write to the reset field is a separate step, so the release order shows on the pins.

Each sequence ends with a one-cycle done pulse. The hold window is a parameterised number of delay units, and each unit is a parameterised number of clock cycles.

Top module: `adapter_init_seq`

## Requirements
- R1: While reset is applied, all three reset outputs are low, both registers read 0, `rate_sel` is 0 and `busy` and `done` are 0.
- R2: A bring-up command accepted at edge E0 raises `core_rst_n` at edge E1. `done` pulses at edge E1+HOLD, where HOLD = UNIT_CYCLES*HOLD_UNITS. No other output changes.
- R3: A full-init command accepted at edge E0 raises `core_rst_n` at edge E1. At edge E2 it drives all three resets low in the same cycle, and they stay low for HOLD+1 cycles.
- R4: After the hold, the resets are released on consecutive edges in this fixed order: core, then system interface, then FIFO.
- R5: On the edge after the FIFO release, `irq_ctrl` is loaded with system-interrupt-enable (bit 1) and bus-error-enable (bit 0) both set, i.e. 0x03.
- R6: On the edge after the `irq_ctrl` write, `fifo_thresh` is loaded with 30 and `done` pulses in that same cycle.
- R7: A power-down command accepted at edge E0 drives all three resets low at edge E1 and pulses `done` in that cycle. `irq_ctrl` and `fifo_thresh` keep their values.
- R8: `done` is high for exactly one cycle. `busy` is high from the edge that accepts a command through the `done` cycle, and low on the next edge.
- R9: A command that arrives while `busy` is high is ignored. The running sequence and every output are unaffected.
- R10: If several commands arrive in the same idle cycle, power-down wins over full init, and full init wins over bring-up.
- R11: `rate_sel` follows `slow_rate` with one cycle of latency. 1 selects 4 Mbps and 0 selects 16 Mbps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_bringup | input | 1 | Pulse: release the core and wait for HOLD |
| cmd_init | input | 1 | Pulse: run the full init sequence |
| cmd_down | input | 1 | Pulse: put all three blocks back into reset |
| slow_rate | input | 1 | 1 requests 4 Mbps, 0 requests 16 Mbps |
| core_rst_n | output | 1 | Chip-core reset, active low |
| sif_rst_n | output | 1 | System-interface reset, active low |
| fifo_rst_n | output | 1 | FIFO reset, active low |
| irq_ctrl | output | REG_W | Interrupt-control register |
| fifo_thresh | output | REG_W | FIFO threshold register |
| rate_sel | output | 1 | Registered line-rate select |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
The bench builds the block with UNIT_CYCLES=3 and HOLD_UNITS=4, so HOLD is 12 cycles. This short window lets each sequence run several times within the run. It also exercises the multiply that sizes the timer with a unit length other than one, so the exact cycle of every release and of every done pulse is checked against the model. Commands are issued during the hold window and during the release steps to cover R9. Simultaneous commands, and a bring-up issued after init has already released the core, cover priority and the case where a reset-field write leaves the field unchanged.

// File: rtl/ainit_pkg.sv
// Shared definitions for the adapter reset/init sequencer.
// Assumes reset-field bit positions are fixed: core, system interface, FIFO.
package ainit_pkg;
    localparam int RST_BITS = 3;
    localparam int RB_CORE  = 0;
    localparam int RB_SIF   = 1;
    localparam int RB_FIFO  = 2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_EN_CORE,
        ST_EN_WAIT,
        ST_IN_CORE,
        ST_IN_ASSERT,
        ST_IN_HOLD,
        ST_IN_REL_CORE,
        ST_IN_REL_SIF,
        ST_IN_REL_FIFO,
        ST_IN_IRQ,
        ST_IN_THR,
        ST_DOWN,
        ST_FINISH
    } step_e;
endpackage

// File: rtl/ainit_timer.sv
// Hold timer: a load starts a window that expires after HOLD cycles.
// Assumes HOLD >= 1. The count saturates at zero until the next load.
module ainit_timer #(
    parameter int HOLD = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
    localparam logic [CW-1:0] LOAD_VAL = CW'(HOLD - 1);

    logic [CW-1:0] cnt_q;

    // Count down from HOLD-1 after a load, stopping at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= LOAD_VAL;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    assert_timer_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q == '0) |=> (cnt_q == '0));
    assert_timer_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == LOAD_VAL));
endmodule

// File: rtl/ainit_fsm.sv
// Step sequencer: accepts one command while idle and walks the steps of
// that command. Each step issues at most one register write.
// Assumes commands are single-cycle pulses. Commands seen while busy are dropped.
module ainit_fsm
    import ainit_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_bringup,
    input  logic                cmd_init,
    input  logic                cmd_down,
    input  logic                timer_expired,
    input  logic [RST_BITS-1:0] cur_rst,
    output logic                timer_load,
    output logic                rst_wr,
    output logic [RST_BITS-1:0] rst_val,
    output logic                irq_wr,
    output logic                thr_wr,
    output logic                busy,
    output logic                done
);
    localparam logic [RST_BITS-1:0] M_CORE = RST_BITS'(1) << RB_CORE;
    localparam logic [RST_BITS-1:0] M_SIF  = RST_BITS'(1) << RB_SIF;
    localparam logic [RST_BITS-1:0] M_FIFO = RST_BITS'(1) << RB_FIFO;

    step_e state_q, state_d;

    // Step register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next step and write strobes for the current step.
    always_comb begin
        state_d    = state_q;
        timer_load = 1'b0;
        rst_wr     = 1'b0;
        rst_val    = cur_rst;
        irq_wr     = 1'b0;
        thr_wr     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_down)         state_d = ST_DOWN;
                else if (cmd_init)    state_d = ST_IN_CORE;
                else if (cmd_bringup) state_d = ST_EN_CORE;
            end
            ST_EN_CORE: begin
                rst_wr = 1'b1; rst_val = cur_rst | M_CORE;
                timer_load = 1'b1; state_d = ST_EN_WAIT;
            end
            ST_EN_WAIT:     if (timer_expired) state_d = ST_FINISH;
            ST_IN_CORE: begin
                rst_wr = 1'b1; rst_val = cur_rst | M_CORE; state_d = ST_IN_ASSERT;
            end
            ST_IN_ASSERT: begin
                rst_wr = 1'b1; rst_val = '0;
                timer_load = 1'b1; state_d = ST_IN_HOLD;
            end
            ST_IN_HOLD:     if (timer_expired) state_d = ST_IN_REL_CORE;
            ST_IN_REL_CORE: begin
                rst_wr = 1'b1; rst_val = cur_rst | M_CORE; state_d = ST_IN_REL_SIF;
            end
            ST_IN_REL_SIF: begin
                rst_wr = 1'b1; rst_val = cur_rst | M_SIF; state_d = ST_IN_REL_FIFO;
            end
            ST_IN_REL_FIFO: begin
                rst_wr = 1'b1; rst_val = cur_rst | M_FIFO; state_d = ST_IN_IRQ;
            end
            ST_IN_IRQ: begin irq_wr = 1'b1; state_d = ST_IN_THR; end
            ST_IN_THR: begin thr_wr = 1'b1; state_d = ST_FINISH; end
            ST_DOWN: begin
                rst_wr = 1'b1; rst_val = '0; state_d = ST_FINISH;
            end
            ST_FINISH:      state_d = ST_IDLE;
            default:        state_d = ST_IDLE;
        endcase
    end

    assign busy = (state_q != ST_IDLE);
    assign done = (state_q == ST_FINISH);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    assert_idle_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    assert_busy_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

// File: rtl/ainit_regs.sv
// Register bank: reset field, interrupt control, FIFO threshold, rate select.
// Assumes the FSM issues at most one write per cycle. Reset puts every line in reset.
module ainit_regs
    import ainit_pkg::*;
#(
    parameter int               REG_W      = 8,
    parameter logic [REG_W-1:0] IRQ_VAL    = 8'h03,
    parameter logic [REG_W-1:0] THRESH_VAL = 8'd30
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rst_wr,
    input  logic [RST_BITS-1:0] rst_val,
    input  logic                irq_wr,
    input  logic                thr_wr,
    input  logic                slow_rate,
    output logic [RST_BITS-1:0] rst_q,
    output logic [REG_W-1:0]    irq_q,
    output logic [REG_W-1:0]    thr_q,
    output logic                rate_q
);
    // Reset field: written as a whole by each reset step.
    always_ff @(posedge clk) begin
        if (!rst_n)      rst_q <= '0;
        else if (rst_wr) rst_q <= rst_val;
    end

    // Interrupt-control and threshold registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= '0;
            thr_q <= '0;
        end else begin
            if (irq_wr) irq_q <= IRQ_VAL;
            if (thr_wr) thr_q <= THRESH_VAL;
        end
    end

    // Rate select: registered copy of the requested rate.
    always_ff @(posedge clk) begin
        if (!rst_n) rate_q <= 1'b0;
        else        rate_q <= slow_rate;
    end

    assert_sif_after_core_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_q[RB_SIF]) |-> rst_q[RB_CORE]);
    assert_fifo_after_sif_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_q[RB_FIFO]) |-> rst_q[RB_SIF]);
    assert_irq_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q != $past(irq_q)) |-> (irq_q == IRQ_VAL));
    assert_thr_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_q != $past(thr_q)) |-> (thr_q == THRESH_VAL));
endmodule

// File: rtl/adapter_init_seq.sv
// Top of the adapter reset/init sequencer. It ties the step FSM, the hold
// timer and the register bank together.
// Assumes the delay unit is UNIT_CYCLES clocks and HOLD_UNITS >= 1.
module adapter_init_seq
    import ainit_pkg::*;
#(
    parameter int UNIT_CYCLES  = 1,
    parameter int HOLD_UNITS   = 100,
    parameter int REG_W        = 8,
    parameter int THRESH       = 30,
    parameter int IRQ_SYS_BIT  = 1,
    parameter int IRQ_ERR_BIT  = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_bringup,
    input  logic             cmd_init,
    input  logic             cmd_down,
    input  logic             slow_rate,
    output logic             core_rst_n,
    output logic             sif_rst_n,
    output logic             fifo_rst_n,
    output logic [REG_W-1:0] irq_ctrl,
    output logic [REG_W-1:0] fifo_thresh,
    output logic             rate_sel,
    output logic             busy,
    output logic             done
);
    localparam int HOLD = UNIT_CYCLES * HOLD_UNITS;
    localparam logic [REG_W-1:0] IRQ_VAL =
        (REG_W'(1) << IRQ_SYS_BIT) | (REG_W'(1) << IRQ_ERR_BIT);
    localparam logic [REG_W-1:0] THRESH_VAL = REG_W'(THRESH);

    logic                timer_load, timer_expired;
    logic                rst_wr, irq_wr, thr_wr;
    logic [RST_BITS-1:0] rst_val, rst_q;

    ainit_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cmd_bringup(cmd_bringup), .cmd_init(cmd_init), .cmd_down(cmd_down),
        .timer_expired(timer_expired), .cur_rst(rst_q),
        .timer_load(timer_load), .rst_wr(rst_wr), .rst_val(rst_val),
        .irq_wr(irq_wr), .thr_wr(thr_wr), .busy(busy), .done(done)
    );

    ainit_timer #(.HOLD(HOLD)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(timer_load), .expired(timer_expired)
    );

    ainit_regs #(.REG_W(REG_W), .IRQ_VAL(IRQ_VAL), .THRESH_VAL(THRESH_VAL)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .rst_wr(rst_wr), .rst_val(rst_val), .irq_wr(irq_wr), .thr_wr(thr_wr),
        .slow_rate(slow_rate),
        .rst_q(rst_q), .irq_q(irq_ctrl), .thr_q(fifo_thresh), .rate_q(rate_sel)
    );

    assign core_rst_n = rst_q[RB_CORE];
    assign sif_rst_n  = rst_q[RB_SIF];
    assign fifo_rst_n = rst_q[RB_FIFO];

    assert_quiet_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(busy) |-> ($stable(rst_q) && $stable(irq_ctrl) && $stable(fifo_thresh)));
    assert_rate_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rate_sel == $past(slow_rate));
endmodule

// File: tb/adapter_init_seq_tb.sv
`timescale 1ns/1ps
module adapter_init_seq_tb;
    localparam int UNIT = 3;
    localparam int UNITS = 4;
    localparam int H = UNIT * UNITS;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0, c_en = 1'b0, c_init = 1'b0, c_down = 1'b0, slow = 1'b0;
    logic core_n, sif_n, fifo_n, rate, busy, done;
    logic [7:0] irq, thr;

    adapter_init_seq #(.UNIT_CYCLES(UNIT), .HOLD_UNITS(UNITS)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_bringup(c_en), .cmd_init(c_init),
        .cmd_down(c_down), .slow_rate(slow),
        .core_rst_n(core_n), .sif_rst_n(sif_n), .fifo_rst_n(fifo_n),
        .irq_ctrl(irq), .fifo_thresh(thr), .rate_sel(rate),
        .busy(busy), .done(done)
    );

    typedef struct packed {
        logic core, sif, fifo;
        logic [7:0] irq, thr;
        logic busy, done;
    } snap_t;

    snap_t exp_s, w, act;
    snap_t q[$];
    string tq[$];
    string cur_tag = "R1";
    logic exp_rate = 1'b0;
    int total = 0, bad = 0, ign_cnt = 0, prio_cnt = 0;

    function automatic void push(snap_t s, string t);
        q.push_back(s);
        tq.push_back(t);
    endfunction

    // Reference model: expected outputs after each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_s = '0; q.delete(); tq.delete(); exp_rate = 1'b0; cur_tag = "R1";
        end else begin
            if (!exp_s.busy && (c_down || c_init || c_en)) begin
                w = exp_s; w.busy = 1'b1; w.done = 1'b0;
                if (c_down) begin
                    push(w, "R7");
                    w.core = 0; w.sif = 0; w.fifo = 0; w.done = 1; push(w, "R7");
                end else if (c_init) begin
                    push(w, "R3");
                    w.core = 1; push(w, "R3");
                    w.core = 0; w.sif = 0; w.fifo = 0; push(w, "R3");
                    for (int i = 0; i < H; i++) push(w, "R3");
                    w.core = 1; push(w, "R4");
                    w.sif = 1;  push(w, "R4");
                    w.fifo = 1; push(w, "R4");
                    w.irq = 8'h03; push(w, "R5");
                    w.thr = 8'd30; w.done = 1; push(w, "R6");
                end else begin
                    push(w, "R2");
                    w.core = 1;
                    for (int i = 0; i < H; i++) push(w, "R2");
                    w.done = 1; push(w, "R2");
                end
            end
            if (q.size() > 0) begin
                exp_s = q.pop_front();
                cur_tag = tq.pop_front();
            end else begin
                exp_s.busy = 1'b0; exp_s.done = 1'b0; cur_tag = "R8";
            end
            exp_rate = slow;
            if (ign_cnt > 0) ign_cnt--;
            if (prio_cnt > 0) prio_cnt--;
        end
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            string t;
            t = (prio_cnt > 0) ? "R10" : (ign_cnt > 0) ? "R9" : cur_tag;
            act = '{core_n, sif_n, fifo_n, irq, thr, busy, done};
            total++;
            if (act !== exp_s) begin
                bad++;
                $display("FAIL %s t=%0t outputs=%h expected=%h", t, $time, act, exp_s);
            end
            total++;
            if (rate !== exp_rate) begin
                bad++;
                $display("FAIL R11 rate_sel=%b expected=%b", rate, exp_rate);
            end
        end
    end

    task automatic cmd(input logic e, input logic i, input logic d);
        @(negedge clk); c_en = e; c_init = i; c_down = d;
        @(negedge clk); c_en = 0; c_init = 0; c_down = 0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy);
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        total++;
        if ({core_n, sif_n, fifo_n, irq, thr, rate, busy, done} !== '0) begin
            bad++;
            $display("FAIL R1 reset outputs=%h expected=0",
                     {core_n, sif_n, fifo_n, irq, thr, rate, busy, done});
        end
        rst_n = 1'b1;
        // R11: rate select toggling while idle
        repeat (2) @(negedge clk); slow = 1;
        repeat (3) @(negedge clk); slow = 0;
        @(negedge clk); slow = 1;
        @(negedge clk);
        // R2 bring-up, with an init request in flight (R9)
        cmd(1, 0, 0);
        repeat (3) @(negedge clk);
        ign_cnt = 4; cmd(0, 1, 0);
        wait_idle();
        // R3..R6 full init, with power-down and bring-up dropped (R9)
        cmd(0, 1, 0);
        repeat (5) @(negedge clk);
        ign_cnt = 4; cmd(0, 0, 1);
        repeat (H) @(negedge clk);
        ign_cnt = 4; cmd(1, 0, 0);
        slow = 0;
        wait_idle();
        // R7 power-down keeps register values
        cmd(0, 0, 1);
        wait_idle();
        // R10 all three together: power-down wins
        prio_cnt = 3; cmd(1, 1, 1);
        wait_idle();
        // R10 init and bring-up together: init wins
        prio_cnt = 4; cmd(1, 1, 0);
        slow = 1;
        wait_idle();
        // R2 bring-up when the core is already released
        cmd(1, 0, 0);
        wait_idle();
        repeat (3) @(negedge clk);
        summary();
        $finish;
    end
endmodule